// File: doc/BRIEF.md
# Cartridge Two-Level Bank Mapper

This block sits between an 8-bit console's CPU and picture-processor buses and the cartridge ROM arrays. It holds a small set of write-only bank registers and turns the bus addresses into extended physical addresses. Program space appears as four 8 KB slots and character space as eight 1 KB slots. Each slot's physical page comes from two registers. A coarse outer register is loaded by CPU writes to the save-RAM window. A fine inner register is loaded by CPU writes to the program-ROM window.

Together the outer and inner registers select a contiguous 32 KB program region and a contiguous 8 KB character region. Page numbers fold onto the ROM sizes actually fitted, which are given as power-of-two parameters. Nametable mirroring is tied to one setting. The ROM arrays, save-RAM storage, audio and interrupt paths are outside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write (cpu_wr high at a rising clock edge) with cpu_addr[15:13] = 3'b011 (0x6000 to 0x7FFF) loads cpu_data[3:0] into the program outer register and cpu_data[7:4] into the character outer register.
- R2: A write with cpu_addr[15] = 1 (0x8000 to 0xFFFF) loads cpu_data[0] into the program inner register and cpu_data[6:4] into the character inner register. Data bits 7 and 3:1 have no effect.
- R3: prg_addr = {program page, cpu_addr[12:0]}. The program page is outer*8 + inner*4 + slot, with slot = cpu_addr[14:13].
- R4: chr_addr = {character page, ppu_addr[9:0]}. The character page is outer*64 + inner*8 + slot, with slot = ppu_addr[12:10].
- R5: Program pages wrap modulo PRG_PAGES and character pages wrap modulo CHR_PAGES.
- R6: While rst_n is low, and after it is released, all registers are zero. Program slots then map to pages 0 to 3 and character slots to pages 0 to 7.
- R7: mirror_sel is always 1, whatever is written.
- R8: A register write changes the page of every slot on the first rising edge that samples it. No second write or unlock step is needed.
- R9: A write with cpu_addr below 0x6000, or any cycle with cpu_wr low, leaves every page unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 13 | Picture-processor pattern address |
| prg_addr | output | log2(PRG_PAGES)+13 | Physical program-ROM address |
| chr_addr | output | log2(CHR_PAGES)+10 | Physical character-ROM address |
| mirror_sel | output | 1 | Nametable mirroring select, fixed at 1 |

## Verification
The bound checker watches the register side on every cycle. A write in either window must leave exactly the decoded data fields in the matching registers. A cycle with no decoded write must leave all of them unchanged. The checker also requires the low bits of each output page to equal the slot number taken from the bus address. The full page arithmetic, the folding onto smaller ROM sizes, the dropped data bits, the reset values and the fixed mirroring can only be shown by the bench. It does this by sweeping every slot after each write sequence and comparing with a reference model.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   localparam int CPU_AW   = 16;
   localparam int DATA_W   = 8;
   localparam int PPU_AW   = 13;
   localparam int PRG_OFS_W = 13;
   localparam int CHR_OFS_W = 10;
   localparam int PRG_SLOTS = 4;
   localparam int CHR_SLOTS = 8;

   localparam int PO_W = 4;
   localparam int CO_W = 4;
   localparam int PI_W = 1;
   localparam int CI_W = 3;

   // page = outer << OUTER_SH + inner << INNER_SH + slot
   localparam int PRG_OUTER_SH = 3;
   localparam int PRG_INNER_SH = 2;
   localparam int CHR_OUTER_SH = 6;
   localparam int CHR_INNER_SH = 3;

   typedef struct packed {
      logic [PO_W-1:0] prg_outer;
      logic [CO_W-1:0] chr_outer;
      logic [PI_W-1:0] prg_inner;
      logic [CI_W-1:0] chr_inner;
   } bank_regs_t;

   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_SAVE = 2'd1,
      WIN_PROG = 2'd2
   } cpu_win_e;

endpackage

// File: rtl/cpu_window_decode.sv
module cpu_window_decode
   import mapper_pkg::*;
(
   input  logic [2:0] addr_hi,
   input  logic       wr,
   output cpu_win_e   win,
   output logic       ld_outer,
   output logic       ld_inner
);

   always_comb begin
      if (addr_hi[2])
         win = WIN_PROG;
      else if (addr_hi == 3'b011)
         win = WIN_SAVE;
      else
         win = WIN_NONE;
   end

   assign ld_outer = wr && (win == WIN_SAVE);
   assign ld_inner = wr && (win == WIN_PROG);

endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
   import mapper_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_outer,
   input  logic              ld_inner,
   input  logic [DATA_W-1:0] wdata,
   output bank_regs_t        regs
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else begin
         if (ld_outer) begin
            regs.prg_outer <= wdata[3:0];
            regs.chr_outer <= wdata[7:4];
         end
         if (ld_inner) begin
            regs.prg_inner <= wdata[0];
            regs.chr_inner <= wdata[6:4];
         end
      end
   end

endmodule

// File: rtl/bank_page_xlate.sv
module bank_page_xlate #(
   parameter int PAGES     = 128,
   parameter int SLOTS     = 4,
   parameter int OUTER_W   = 4,
   parameter int INNER_W   = 1,
   parameter int OUTER_SH  = 3,
   parameter int INNER_SH  = 2,
   parameter int OFFSET_W  = 13,
   localparam int PAGE_W   = $clog2(PAGES),
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int ADDR_W   = PAGE_W + OFFSET_W
) (
   input  logic [OUTER_W-1:0]  outer,
   input  logic [INNER_W-1:0]  inner,
   input  logic [SLOT_W-1:0]   slot,
   input  logic [OFFSET_W-1:0] offset,
   output logic [ADDR_W-1:0]   addr
);

   localparam int RAW_W = OUTER_W + OUTER_SH;

   if ((1 << PAGE_W) != PAGES || PAGES < SLOTS) begin : g_bad_pages
      $error("bank_page_xlate: PAGES must be a power of two >= SLOTS");
   end
   if ((1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("bank_page_xlate: SLOTS must be a power of two");
   end
   if (INNER_SH + INNER_W > OUTER_SH || SLOT_W > INNER_SH) begin : g_bad_split
      $error("bank_page_xlate: inner field overlaps outer field or slot");
   end

   logic [PAGE_W-1:0] slot_page [SLOTS];

   // Arithmetic is done in PAGE_W bits, so a narrower ROM folds by masking.
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (PAGE_W >= RAW_W) begin : g_full
         assign slot_page[s] = (PAGE_W'(outer) << OUTER_SH)
                             + (PAGE_W'(inner) << INNER_SH)
                             + PAGE_W'(s);
      end else begin : g_fold
         logic [PAGE_W-1:0] folded;
         assign folded = (PAGE_W'(outer) << OUTER_SH)
                       + (PAGE_W'(inner) << INNER_SH)
                       + PAGE_W'(s);
         assign slot_page[s] = folded;
      end
   end

   assign addr = {slot_page[slot], offset};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import mapper_pkg::*;
#(
   parameter int PRG_PAGES = 128,
   parameter int CHR_PAGES = 1024,
   localparam int PRG_AW   = $clog2(PRG_PAGES) + PRG_OFS_W,
   localparam int CHR_AW   = $clog2(CHR_PAGES) + CHR_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_wr,
   input  logic [PPU_AW-1:0] ppu_addr,
   output logic [PRG_AW-1:0] prg_addr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              mirror_sel
);

   if (PRG_PAGES < PRG_SLOTS || CHR_PAGES < CHR_SLOTS) begin : g_bad_size
      $error("cart_bank_mapper: ROM smaller than one slot set");
   end

   cpu_win_e   win;
   logic       ld_outer;
   logic       ld_inner;
   bank_regs_t regs_q;

   cpu_window_decode u_dec (
      .addr_hi  (cpu_addr[15:13]),
      .wr       (cpu_wr),
      .win      (win),
      .ld_outer (ld_outer),
      .ld_inner (ld_inner)
   );

   bank_reg_file u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_outer (ld_outer),
      .ld_inner (ld_inner),
      .wdata    (cpu_data),
      .regs     (regs_q)
   );

   bank_page_xlate #(
      .PAGES    (PRG_PAGES),
      .SLOTS    (PRG_SLOTS),
      .OUTER_W  (PO_W),
      .INNER_W  (PI_W),
      .OUTER_SH (PRG_OUTER_SH),
      .INNER_SH (PRG_INNER_SH),
      .OFFSET_W (PRG_OFS_W)
   ) u_prg (
      .outer  (regs_q.prg_outer),
      .inner  (regs_q.prg_inner),
      .slot   (cpu_addr[14:13]),
      .offset (cpu_addr[12:0]),
      .addr   (prg_addr)
   );

   bank_page_xlate #(
      .PAGES    (CHR_PAGES),
      .SLOTS    (CHR_SLOTS),
      .OUTER_W  (CO_W),
      .INNER_W  (CI_W),
      .OUTER_SH (CHR_OUTER_SH),
      .INNER_SH (CHR_INNER_SH),
      .OFFSET_W (CHR_OFS_W)
   ) u_chr (
      .outer  (regs_q.chr_outer),
      .inner  (regs_q.chr_inner),
      .slot   (ppu_addr[12:10]),
      .offset (ppu_addr[9:0]),
      .addr   (chr_addr)
   );

   assign mirror_sel = 1'b1;

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
   import mapper_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cpu_hi,
   input logic [DATA_W-1:0] cpu_data,
   input logic              cpu_wr,
   input logic [2:0]        ppu_slot,
   input bank_regs_t        regs,
   input logic [1:0]        prg_page_lo,
   input logic [2:0]        chr_page_lo
);

   logic save_wr;
   logic prog_wr;
   assign save_wr = cpu_wr && (cpu_hi == 3'b011);
   assign prog_wr = cpu_wr && cpu_hi[2];

   // R1
   p_outer_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      save_wr |=> (regs.prg_outer == $past(cpu_data[3:0]))
               && (regs.chr_outer == $past(cpu_data[7:4])));

   // R2
   p_inner_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_wr |=> (regs.prg_inner == $past(cpu_data[0]))
               && (regs.chr_inner == $past(cpu_data[6:4])));

   // R9
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(save_wr || prog_wr) |=> $stable(regs));

   // R3
   p_prg_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prg_page_lo == cpu_hi[1:0]);

   // R4
   p_chr_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chr_page_lo == ppu_slot);

endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_hi      (cpu_addr[15:13]),
   .cpu_data    (cpu_data),
   .cpu_wr      (cpu_wr),
   .ppu_slot    (ppu_addr[12:10]),
   .regs        (regs_q),
   .prg_page_lo (prg_addr[14:13]),
   .chr_page_lo (chr_addr[12:10])
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

   localparam int SP_PRG = 16;
   localparam int SP_CHR = 64;
   localparam int NVEC = 8;

   // {address, data}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h6000_A5, 24'h8000_71, 24'h7FFF_3C, 24'hFFFF_00,
      24'h5FFF_FF, 24'hC123_5F, 24'h6ABC_F9, 24'h8000_8E
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0;
   logic [7:0]  cpu_data = 8'h0;
   logic        cpu_wr = 1'b0;
   logic [12:0] ppu_addr = 13'h0;
   logic [19:0] prg_addr;
   logic [19:0] chr_addr;
   logic        mirror_sel;
   logic [16:0] prg_addr_s;
   logic [15:0] chr_addr_s;
   logic        mirror_sel_s;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   int m_po = 0, m_co = 0, m_pi = 0, m_ci = 0;

   always #10 clk = ~clk;

   cart_bank_mapper dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
      .chr_addr(chr_addr), .mirror_sel(mirror_sel)
   );

   cart_bank_mapper #(.PRG_PAGES(SP_PRG), .CHR_PAGES(SP_CHR)) dut_small (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr_s),
      .chr_addr(chr_addr_s), .mirror_sel(mirror_sel_s)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_write(logic [15:0] a, logic [7:0] d);
      if (a[15:13] == 3'b011) begin
         m_po = int'(d[3:0]);
         m_co = int'(d[7:4]);
      end else if (a[15]) begin
         m_pi = int'(d[0]);
         m_ci = int'(d[6:4]);
      end
   endtask

   task automatic bus_write(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      cpu_addr = a;
      cpu_data = d;
      cpu_wr   = 1'b1;
      @(negedge clk);
      cpu_wr   = 1'b0;
      model_write(a, d);
   endtask

   // Visit every slot of both spaces and compare with the model.
   task automatic sweep(string tag);
      for (int s = 0; s < 4; s++) begin
         cpu_addr = 16'h8000 + 16'(s * 8192) + 16'h0123;
         #2;
         chk({tag, " R3 prg"}, 32'(prg_addr),
             ((m_po * 8 + m_pi * 4 + s) % 128) * 8192 + 32'h0123);
         chk({tag, " R5 prg small"}, 32'(prg_addr_s),
             ((m_po * 8 + m_pi * 4 + s) % SP_PRG) * 8192 + 32'h0123);
      end
      for (int s = 0; s < 8; s++) begin
         ppu_addr = 13'(s * 1024) + 13'h2B5;
         #2;
         chk({tag, " R4 chr"}, 32'(chr_addr),
             ((m_co * 64 + m_ci * 8 + s) % 1024) * 1024 + 32'h2B5);
         chk({tag, " R5 chr small"}, 32'(chr_addr_s),
             ((m_co * 64 + m_ci * 8 + s) % SP_CHR) * 1024 + 32'h2B5);
      end
      chk({tag, " R7 mirror"}, 32'(mirror_sel), 32'd1);
      chk({tag, " R7 mirror small"}, 32'(mirror_sel_s), 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // R6: values during and after reset
      repeat (3) @(negedge clk);
      sweep("R6 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R6 after reset");

      // Table walk; every entry is followed by a full slot sweep (R8).
      for (int i = 0; i < NVEC; i++) begin
         bus_write(VEC[i][23:8], VEC[i][7:0]);
         sweep("R8 table R1 R2");
      end

      // R2: ignored data bits 7 and 3:1
      bus_write(16'h9000, 8'h8E);
      sweep("R2 ignored bits");

      // R9: writes below 0x6000 in several places
      bus_write(16'h6000, 8'h96);
      bus_write(16'h8000, 8'h61);
      bus_write(16'h0000, 8'h00);
      bus_write(16'h2000, 8'h11);
      bus_write(16'h4017, 8'hFF);
      sweep("R9 low writes");

      // R9: strobe low with both windows on the bus
      @(negedge clk);
      cpu_addr = 16'h6000;
      cpu_data = 8'h00;
      repeat (3) @(negedge clk);
      cpu_addr = 16'hA000;
      repeat (3) @(negedge clk);
      sweep("R9 strobe low");

      // R5: fold at the top of both ranges
      bus_write(16'h7000, 8'hFF);
      bus_write(16'hE000, 8'h71);
      sweep("R5 top fold");

      // R8: one write moves all slots at once, back-to-back writes
      bus_write(16'h6000, 8'h12);
      bus_write(16'h6000, 8'h21);
      sweep("R8 back to back");

      // R6: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      m_po = 0; m_co = 0; m_pi = 0; m_ci = 0;
      @(negedge clk);
      sweep("R6 mid reset");
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R6 released");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule